// File: doc/BRIEF.md
# Chainable Bitstream Configuration Store

This block is a read-only store that streams a configuration image to a programmable device. A fixed image sits in an internal table and is indexed by an address counter. The output stage presents the image in one of two ways. In serial mode it sends one bit per clock on data bit 0, most significant bit of each byte first. In parallel mode it sends one whole byte per clock. An active-low chip select gates the stream. A combined output-enable/reset input releases the outputs and rewinds the stream whenever it is low.

Several stores can be linked into one longer image. All of them share the clock, the mode select and the data lines. The chain-enable output of each store feeds the chip select of the next one. Once a store has presented its last item, it stops driving and raises no further data. The next store then begins in the very next clock, so the chain reads as one unbroken stream.

The output side follows a valid-only stream rule. `dout_drv` marks each cycle in which `dout` carries an item. There is no ready input: the reader must accept one item on every clock in which `dout_drv` is high. Back-pressure is applied by raising `ce_n`, which freezes the position in the stream. At 33 MHz in parallel mode the store delivers 264 Mb/s.

Top module: `cfgmem_chainable`

## Requirements
- R1: While `oe_rstn` is low, the address and bit position return to the start, `dout_drv` is 0, `dout` is 0 and `ceo_n` is 1, whatever `ce_n` is.
- R2: `dout_drv` is 1 exactly when `ce_n` is 0, `oe_rstn` is 1 and the image is not yet exhausted. Whenever `dout_drv` is 0, `dout` is all zeros, so stores sharing the data lines can be OR-combined.
- R3: With `par_sel` = 1, the first cycle after enabling presents image byte 0 on `dout[7:0]`. Each rising clock edge with `dout_drv` high advances to the next byte.
- R4: With `par_sel` = 0, `dout[0]` carries bit 7 of the current byte first and bit 0 last, one bit per rising edge, and `dout[7:1]` is 0. The byte address advances after the eighth bit.
- R5: Image byte i equals (SEED + 37*i) mod 256, where SEED is a parameter, for i from 0 to DEPTH-1.
- R6: `ceo_n` falls at the rising edge that ends the last item: byte DEPTH-1 in parallel mode, or bit 0 of byte DEPTH-1 in serial mode. It then stays low, with `dout_drv` low, until `oe_rstn` goes low.
- R7: A rising edge with `ce_n` high does not move the stream position. When `ce_n` returns low, the item that was next is presented.
- R8: In a chain where one store's `ceo_n` drives the next store's `ce_n`, the first byte or bit of the next store appears in the cycle right after the last item of the previous store. At most one store drives at a time.
- R9: Pulling `oe_rstn` low in the middle of a stream and raising it again restarts the chain at byte 0 (bit 7) of the first store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; the stream advances on its rising edge |
| ce_n | input | 1 | Active-low chip select; high holds the stream position |
| oe_rstn | input | 1 | Output enable, active high; low asynchronously rewinds and releases the outputs |
| par_sel | input | 1 | 1 selects byte-wide output, 0 selects bit-serial output on bit 0 |
| dout | output | 8 | Stream data; all zeros when not driving |
| dout_drv | output | 1 | Valid/drive flag for `dout` |
| ceo_n | output | 1 | Active-low chain enable for the next store; low once this image is exhausted |

## Verification
The checker watches several properties on every clock. It confirms that the bus is quiet whenever the drive flag is low. It confirms that a deselected or exhausted store never drives. It confirms that the chain-enable output, once low, holds until reset, and that the upper seven bits stay zero in serial mode. Other properties can only be shown by the bench's scenarios against a scoreboard of expected per-cycle values. These are the order of the image contents, the MSB-first bit order, the exact cycle of the hand-off between two chained stores, the freeze under a chip-select stall, and the rewind after a mid-stream reset.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } xfer_mode_e;

  // Image byte at index idx for a given seed: (seed + 37*idx) mod 256.
  function automatic logic [BYTE_W-1:0] image_byte(input logic [BYTE_W-1:0] seed,
                                                   input int idx);
    int sum;
    sum = int'(seed) + 37 * idx;
    return BYTE_W'(sum % 256);
  endfunction

endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store
  import cfgmem_pkg::*;
#(
  parameter int               DEPTH = 16,
  parameter int               AW    = 4,
  parameter logic [BYTE_W-1:0] SEED = 8'h5A
) (
  input  logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] rd_byte
);

  logic [BYTE_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = image_byte(SEED, i);
  end

  assign rd_byte = rom[addr];

endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  xfer_mode_e       mode,
  output logic [AW-1:0]    addr,
  output logic [BIT_W-1:0] bit_idx,
  output logic             done
);

  localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

  logic word_end;
  logic last_word;

  assign word_end  = (mode == MODE_PARALLEL) || (bit_idx == LAST_BIT);
  assign last_word = (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else if (step) begin
      bit_idx <= word_end ? '0 : bit_idx + BIT_W'(1);
      if (word_end) begin
        if (last_word) done <= 1'b1;
        else           addr <= addr + AW'(1);
      end
    end
  end

endmodule

// File: rtl/cfgmem_out.sv
module cfgmem_out
  import cfgmem_pkg::*;
(
  input  logic              active,
  input  xfer_mode_e        mode,
  input  logic [BYTE_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_drv
);

  localparam logic [BIT_W-1:0] MSB_POS = BIT_W'(BYTE_W - 1);

  always_comb begin
    dout = '0;
    if (active) begin
      if (mode == MODE_PARALLEL) dout = word;
      else                       dout[0] = word[MSB_POS - bit_idx];
    end
  end

  assign dout_drv = active;

endmodule

// File: rtl/cfgmem_chainable.sv
module cfgmem_chainable
  import cfgmem_pkg::*;
#(
  parameter int                DEPTH = 16,
  parameter logic [BYTE_W-1:0] SEED  = 8'h5A
) (
  input  logic              clk,
  input  logic              ce_n,
  input  logic              oe_rstn,
  input  logic              par_sel,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_drv,
  output logic              ceo_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  xfer_mode_e        mode;
  logic [AW-1:0]     addr;
  logic [BIT_W-1:0]  bit_idx;
  logic              done;
  logic              active;
  logic [BYTE_W-1:0] word;

  assign mode   = par_sel ? MODE_PARALLEL : MODE_SERIAL;
  assign active = !ce_n && oe_rstn && !done;

  cfgmem_store #(.DEPTH(DEPTH), .AW(AW), .SEED(SEED)) u_store (
    .addr    (addr),
    .rd_byte (word)
  );

  cfgmem_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (oe_rstn),
    .step    (active),
    .mode    (mode),
    .addr    (addr),
    .bit_idx (bit_idx),
    .done    (done)
  );

  cfgmem_out u_out (
    .active   (active),
    .mode     (mode),
    .word     (word),
    .bit_idx  (bit_idx),
    .dout     (dout),
    .dout_drv (dout_drv)
  );

  assign ceo_n = !done;

endmodule

// File: rtl/cfgmem_chainable_chk.sv
module cfgmem_chainable_chk (
  input logic       clk,
  input logic       ce_n,
  input logic       oe_rstn,
  input logic       par_sel,
  input logic [7:0] dout,
  input logic       dout_drv,
  input logic       ceo_n
);

  // R1
  always @(negedge clk) begin
    if (oe_rstn === 1'b0) begin
      reset_idle_chk: assert (dout_drv == 1'b0 && ceo_n == 1'b1 && dout == 8'h00);
    end
  end

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!oe_rstn)
    !dout_drv |-> dout == 8'h00);

  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!oe_rstn)
    ce_n |-> !dout_drv);

  // R4
  serial_width_chk: assert property (@(posedge clk) disable iff (!oe_rstn)
    (dout_drv && !par_sel) |-> dout[7:1] == 7'd0);

  // R6
  ceo_sticky_chk: assert property (@(posedge clk) disable iff (!oe_rstn)
    !ceo_n |=> !ceo_n);

  // R6
  spent_silent_chk: assert property (@(posedge clk) disable iff (!oe_rstn)
    !ceo_n |-> !dout_drv);

endmodule

bind cfgmem_chainable cfgmem_chainable_chk u_chk (
  .clk      (clk),
  .ce_n     (ce_n),
  .oe_rstn  (oe_rstn),
  .par_sel  (par_sel),
  .dout     (dout),
  .dout_drv (dout_drv),
  .ceo_n    (ceo_n)
);

// File: tb/cfgmem_chainable_bench.sv
module cfgmem_chainable_bench;

  localparam int         DEPTH  = 16;
  localparam logic [7:0] SEED_A = 8'h11;
  localparam logic [7:0] SEED_B = 8'hA5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       oe_rstn, ce_a_n, par_sel;
  logic [7:0] dout_a, dout_b;
  logic       drv_a, drv_b, ceo_a_n, ceo_b_n;

  cfgmem_chainable #(.DEPTH(DEPTH), .SEED(SEED_A)) u_cfgmem_chainable (
    .clk(clk), .ce_n(ce_a_n), .oe_rstn(oe_rstn), .par_sel(par_sel),
    .dout(dout_a), .dout_drv(drv_a), .ceo_n(ceo_a_n)
  );

  cfgmem_chainable #(.DEPTH(DEPTH), .SEED(SEED_B)) u_cfgmem_chainable_nxt (
    .clk(clk), .ce_n(ceo_a_n), .oe_rstn(oe_rstn), .par_sel(par_sel),
    .dout(dout_b), .dout_drv(drv_b), .ceo_n(ceo_b_n)
  );

  logic [7:0] bus;
  logic       any_drv;
  assign bus     = dout_a | dout_b;
  assign any_drv = drv_a | drv_b;

  typedef struct {
    logic       drv;
    logic [7:0] data;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    sb_on  = 1'b0;
  int    cyc    = 0;

  // R5: byte i = (seed + 37*i) mod 256
  function automatic logic [7:0] img(input logic [7:0] seed, input int i);
    return 8'((int'(seed) + 37 * i) % 256);
  endfunction

  task automatic push(input logic drv, input logic [7:0] data, input string tag);
    item_t it;
    it.drv = drv; it.data = data; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Items first..last of one store; serial item j is bit 7-(j%8) of byte j/8.
  task automatic push_seg(input logic [7:0] seed, input bit par,
                          input int first, input int last, input string tag);
    for (int j = first; j <= last; j++) begin
      if (par) push(1'b1, img(seed, j), tag);
      else begin
        logic [7:0] b;
        b = img(seed, j / 8);
        push(1'b1, {7'd0, b[7 - (j % 8)]}, tag);
      end
    end
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int k = 0; k < n; k++) push(1'b0, 8'h00, tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (sb_on) begin
      checks++;
      if (drv_a && drv_b) begin
        fails++;
        $display("FAIL R8: actual 2 drivers expected at most 1");
      end
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        check({any_drv, bus} == {e.drv, e.data}, e.tag,
              int'({any_drv, bus}), int'({e.drv, e.data}));
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
    sb_on = 1'b0;
  endtask

  initial begin
    oe_rstn = 1'b0; ce_a_n = 1'b1; par_sel = 1'b0;
    repeat (3) @(posedge clk);
    #2 ce_a_n = 1'b0;
    @(negedge clk);
    // R1: reset holds outputs released even with chip select low
    check(!drv_a && !drv_b, "R1", int'({drv_a, drv_b}), 0);
    check(ceo_a_n && ceo_b_n, "R1", int'({ceo_a_n, ceo_b_n}), 3);
    check(bus == 8'h00, "R1", int'(bus), 0);

    // Scenario 1: parallel chain end to end (R3, R5, R8, R6)
    push_seg(SEED_A, 1'b1, 0, DEPTH - 1, "R3");
    push_seg(SEED_B, 1'b1, 0, DEPTH - 1, "R5");
    push_idle(3, "R6");
    @(posedge clk); #2;
    oe_rstn = 1'b1; par_sel = 1'b1; sb_on = 1'b1;
    drain();
    // R6: both chain enables low once exhausted
    check(!ceo_a_n && !ceo_b_n, "R6", int'({ceo_a_n, ceo_b_n}), 0);

    // R1: reset rewinds and releases chain enables
    @(posedge clk); #2 oe_rstn = 1'b0; par_sel = 1'b0;
    @(negedge clk);
    check(ceo_a_n && ceo_b_n, "R1", int'({ceo_a_n, ceo_b_n}), 3);
    check(!any_drv, "R1", int'(any_drv), 0);

    // Scenario 2: serial chain with a chip-select stall (R4, R7, R8)
    push_seg(SEED_A, 1'b0, 0, 4, "R4");
    push_idle(4, "R7");
    push_seg(SEED_A, 1'b0, 5, DEPTH * 8 - 1, "R7");
    push_seg(SEED_B, 1'b0, 0, DEPTH * 8 - 1, "R8");
    push_idle(2, "R6");
    @(posedge clk); #2;
    oe_rstn = 1'b1; sb_on = 1'b1;
    repeat (5) @(posedge clk); #2 ce_a_n = 1'b1;
    repeat (4) @(posedge clk); #2 ce_a_n = 1'b0;
    drain();
    // R6: serial exhaustion also raises the hand-off
    check(!ceo_a_n && !ceo_b_n, "R6", int'({ceo_a_n, ceo_b_n}), 0);

    // Scenario 3: mid-stream reset restarts at byte 0 (R9)
    @(posedge clk); #2 oe_rstn = 1'b0; par_sel = 1'b1;
    push_seg(SEED_A, 1'b1, 0, 5, "R3");
    push_idle(2, "R1");
    push_seg(SEED_A, 1'b1, 0, DEPTH - 1, "R9");
    push_seg(SEED_B, 1'b1, 0, DEPTH - 1, "R8");
    push_idle(1, "R2");
    @(posedge clk); #2;
    oe_rstn = 1'b1; sb_on = 1'b1;
    repeat (6) @(posedge clk); #2 oe_rstn = 1'b0;
    repeat (2) @(posedge clk); #2 oe_rstn = 1'b1;
    drain();

    // R2: deselected first store, nothing drives
    @(posedge clk); #2 oe_rstn = 1'b0;
    @(posedge clk); #2 oe_rstn = 1'b1; ce_a_n = 1'b1;
    @(negedge clk);
    check(!any_drv && bus == 8'h00, "R2", int'({any_drv, bus}), 0);

    finish_run();
  end

endmodule